// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Unit

This block supplies the two ALU operands of a five-stage integer pipeline in the execute stage. Each operand comes from one of three sources: the value read from the register file during decode, the result now held in the stage after execute, or the value that the writeback stage is writing this cycle. The choice is made by comparing register numbers, so a dependent instruction gets its operand without waiting for the producer to retire. When both later stages hold a result for the same register, the result in the stage just after execute wins because it is the newer one.

The block also holds the flip-flop register file. Writeback writes it on the clock edge. A decode-stage read of the register being written in that same cycle returns the incoming value, because a flip-flop array cannot write first and read later within one cycle. A small decode-to-execute latch carries the register numbers and read values into the execute stage. The enclosing pipeline must still stall the instruction that directly follows a load. A load's data exists only in writeback, and this block forwards whatever the later-stage result port carries.

Top module: `fwd_operand_unit`

## Requirements
- R1: If the later-stage (EX/MEM) port has `mem_we`=1, `mem_rd`≠0 and `mem_rd` equal to an operand's source register, that operand's select is 2'b10 and the operand equals `mem_val`.
- R2: If only the writeback port matches (`wb_we`=1, `wb_rd`≠0, `wb_rd` equal to the source register), the select is 2'b01 and the operand equals `wb_val`.
- R3: If both ports match the same source register, the later-stage result wins: the select is 2'b10 and the operand is `mem_val`.
- R4: Register 0 never matches a forwarding port, and an operand whose source is register 0 is always 0.
- R5: A port whose write enable is 0 never matches, whatever its destination number.
- R6: With no match, the select is 2'b00 and the operand is the register-file value read in the previous (decode) cycle.
- R7: A decode read of the register that writeback writes in the same cycle returns `wb_val`. The following cycle, the execute-stage operand for that register equals `wb_val` with select 2'b00.
- R8: The two operands are resolved independently, each with its own select. A select is never 2'b11.
- R9: While `rst_n` is low, the register file and the execute latch are cleared. With both write enables low, both selects are 2'b00 and both operands are 0.
- R10: A writeback to register 0 changes no stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs_a | input | 5 | Decode-stage source register, operand A |
| id_rs_b | input | 5 | Decode-stage source register, operand B |
| mem_we | input | 1 | Later-stage (EX/MEM) instruction writes a register |
| mem_rd | input | 5 | Later-stage destination register |
| mem_val | input | 32 | Later-stage ALU result |
| wb_we | input | 1 | Writeback enable |
| wb_rd | input | 5 | Writeback destination register |
| wb_val | input | 32 | Writeback data |
| sel_a | output | 2 | Operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Operand B source, same encoding |
| op_a | output | 32 | Execute-stage operand A |
| op_b | output | 32 | Execute-stage operand B |

## Verification
The selects and operands are combinational in the current later-stage and writeback inputs, so they are due in the same cycle those inputs are applied. The bench drives those inputs at a falling edge and samples 1 ns later. The register-file value and the write-through path reach the operands one rising edge after the decode address is applied. Register writes land on the rising edge that ends the cycle in which `wb_we` is applied. The bench therefore keeps each writeback active across exactly one rising edge and updates its own model of the register contents at that edge, before predicting any later read.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_rd,
    input  logic          wb_we,
    input  logic [AW-1:0] wb_rd,
    output logic [1:0]    sel
);
    logic hit_mem, hit_wb;

    always_comb begin
        hit_mem = mem_we && (mem_rd != '0) && (mem_rd == src);
        hit_wb  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        // newest producer first
        if (hit_mem)     sel = FWD_MEM;
        else if (hit_wb) sel = FWD_WB;
        else             sel = FWD_RF;
    end

    // R8: never both paths at once
    a_r8_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [1:0]    sel,
    input  logic [DW-1:0] rf_val,
    input  logic [DW-1:0] mem_val,
    input  logic [DW-1:0] wb_val,
    output logic [DW-1:0] op
);
    always_comb begin
        unique case (sel)
            FWD_MEM: op = mem_val;
            FWD_WB:  op = wb_val;
            default: op = rf_val;
        endcase
    end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass #(
    parameter int DW  = 32,
    parameter int AW  = 5,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem_d [NREG];
    logic [DW-1:0] mem_q [NREG];
    logic          wr_ok;

    assign wr_ok = we && (waddr != '0);

    always_comb begin
        for (int r = 0; r < NREG; r++) mem_d[r] = mem_q[r];
        if (wr_ok) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) mem_q[r] <= '0;
            else        mem_q[r] <= mem_d[r];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // write-through: a same-cycle write to the read address is returned
        assign rdata[p] = (wr_ok && (waddr == raddr[p])) ? wdata : mem_q[raddr[p]];

        // R10: register 0 reads zero
        a_r10_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
            (raddr[p] == '0) |-> (rdata[p] == '0));

        // R7: a write is visible on the next cycle's read
        a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(wr_ok) && (raddr[p] == $past(waddr))
             && !(wr_ok && (waddr == raddr[p])))
            |-> (rdata[p] == $past(wdata)));
    end
endmodule

// File: rtl/fwd_operand_unit.sv
module fwd_operand_unit
    import fwd_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_rs_a,
    input  logic [AW-1:0] id_rs_b,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_rd,
    input  logic [DW-1:0] mem_val,
    input  logic          wb_we,
    input  logic [AW-1:0] wb_rd,
    input  logic [DW-1:0] wb_val,
    output logic [1:0]    sel_a,
    output logic [1:0]    sel_b,
    output logic [DW-1:0] op_a,
    output logic [DW-1:0] op_b
);
    localparam int NOP = 2;

    typedef struct packed {
        logic [NOP-1:0][AW-1:0] src;
        logic [NOP-1:0][DW-1:0] rfv;
    } ex_latch_t;

    ex_latch_t               ex_d, ex_q;
    logic [NOP-1:0][AW-1:0]  id_src;
    logic [NOP-1:0][DW-1:0]  rd_val;
    logic [NOP-1:0][1:0]     sel;
    logic [NOP-1:0][DW-1:0]  op;

    assign id_src[0] = id_rs_a;
    assign id_src[1] = id_rs_b;

    regfile_bypass #(.DW(DW), .AW(AW), .NRD(NOP)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .waddr (wb_rd),
        .wdata (wb_val),
        .raddr (id_src),
        .rdata (rd_val)
    );

    always_comb begin
        ex_d     = ex_q;
        ex_d.src = id_src;
        ex_d.rfv = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ex_q <= '0;
        else        ex_q <= ex_d;
    end

    for (genvar i = 0; i < NOP; i++) begin : g_op
        fwd_select #(.AW(AW)) u_sel (
            .clk    (clk),
            .rst_n  (rst_n),
            .src    (ex_q.src[i]),
            .mem_we (mem_we),
            .mem_rd (mem_rd),
            .wb_we  (wb_we),
            .wb_rd  (wb_rd),
            .sel    (sel[i])
        );

        fwd_operand_mux #(.DW(DW)) u_mux (
            .sel     (sel[i]),
            .rf_val  (ex_q.rfv[i]),
            .mem_val (mem_val),
            .wb_val  (wb_val),
            .op      (op[i])
        );

        // R1: later-stage path delivers its result
        a_r1_mem_path: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[i] == FWD_MEM) |-> (op[i] == mem_val));

        // R2: writeback path delivers its data
        a_r2_wb_path: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[i] == FWD_WB) |-> (op[i] == wb_val));

        // R4: register 0 operand is zero end to end
        a_r4_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_q.src[i] == '0) |-> ((op[i] == '0) && (sel[i] == FWD_RF)));
    end

    assign sel_a = sel[0];
    assign sel_b = sel[1];
    assign op_a  = op[0];
    assign op_b  = op[1];
endmodule

// File: tb/tb_fwd_operand_unit.sv
`timescale 1ns/1ps
module tb_fwd_operand_unit;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int NV = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs_a = '0, id_rs_b = '0;
    logic          mem_we = 1'b0, wb_we = 1'b0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic [DW-1:0] mem_val = '0, wb_val = '0;
    logic [1:0]    sel_a, sel_b;
    logic [DW-1:0] op_a, op_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [DW-1:0] shadow [32];

    always #2 clk = ~clk;

    fwd_operand_unit #(.DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .id_rs_a(id_rs_a), .id_rs_b(id_rs_b),
        .mem_we(mem_we), .mem_rd(mem_rd), .mem_val(mem_val),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_val(wb_val),
        .sel_a(sel_a), .sel_b(sel_b), .op_a(op_a), .op_b(op_b)
    );

    // {rs_a, rs_b, mem_we, mem_rd, wb_we, wb_rd, exp_sel_a, exp_sel_b}
    localparam logic [25:0] VEC [NV] = '{
        {5'd1,  5'd2,  1'b1, 5'd1,  1'b0, 5'd0,  2'b10, 2'b00}, // R1
        {5'd3,  5'd4,  1'b0, 5'd0,  1'b1, 5'd4,  2'b00, 2'b01}, // R2
        {5'd5,  5'd5,  1'b1, 5'd5,  1'b1, 5'd5,  2'b10, 2'b10}, // R3
        {5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 5'd0,  2'b00, 2'b00}, // R4
        {5'd6,  5'd7,  1'b0, 5'd6,  1'b0, 5'd7,  2'b00, 2'b00}, // R5
        {5'd8,  5'd9,  1'b1, 5'd9,  1'b1, 5'd8,  2'b01, 2'b10}, // R8
        {5'd10, 5'd10, 1'b1, 5'd11, 1'b1, 5'd12, 2'b00, 2'b00}, // R6
        {5'd31, 5'd1,  1'b0, 5'd31, 1'b1, 5'd31, 2'b01, 2'b00}, // R5/R2
        {5'd2,  5'd31, 1'b1, 5'd31, 1'b0, 5'd2,  2'b00, 2'b10}, // R1
        {5'd12, 5'd12, 1'b1, 5'd12, 1'b0, 5'd12, 2'b10, 2'b10}, // R1
        {5'd4,  5'd8,  1'b0, 5'd0,  1'b0, 5'd0,  2'b00, 2'b00}  // R6
    };

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic commit_wb();
        if (wb_we && wb_rd != 0) shadow[wb_rd] = wb_val;
    endtask

    function automatic logic [DW-1:0] pick(input logic [1:0] s, input logic [AW-1:0] r);
        if (s == 2'b10) return mem_val;
        if (s == 2'b01) return wb_val;
        return shadow[r];
    endfunction

    initial begin
        for (int r = 0; r < 32; r++) shadow[r] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R9 reset state
        chk(sel_a == 2'b00 && sel_b == 2'b00, "R9 sel in reset", {30'd0, sel_a}, 0);
        chk(op_a == 0 && op_b == 0, "R9 op in reset", op_a | op_b, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            e = VEC[v];
            @(negedge clk);
            id_rs_a = e[25:21]; id_rs_b = e[20:16];
            mem_we = 1'b0; wb_we = 1'b0;
            @(posedge clk);
            @(negedge clk);
            mem_we = e[15]; mem_rd = e[14:10];
            wb_we = e[9];   wb_rd = e[8:4];
            mem_val = 32'hA000_0000 + v;
            wb_val  = 32'hB000_0000 + v * 16 + e[8:4];
            #1;
            chk(sel_a == e[3:2], $sformatf("R1-table vec%0d sel_a (R1 R2 R3 R4 R5 R6 R8)", v), {30'd0, sel_a}, {30'd0, e[3:2]});
            chk(sel_b == e[1:0], $sformatf("R8 vec%0d sel_b", v), {30'd0, sel_b}, {30'd0, e[1:0]});
            chk(op_a == pick(e[3:2], e[25:21]), $sformatf("R6 vec%0d op_a", v), op_a, pick(e[3:2], e[25:21]));
            chk(op_b == pick(e[1:0], e[20:16]), $sformatf("R6 vec%0d op_b", v), op_b, pick(e[1:0], e[20:16]));
            @(posedge clk);
            commit_wb();
        end

        // R7 same-cycle write-through
        @(negedge clk);
        mem_we = 1'b0;
        id_rs_a = 5'd20; id_rs_b = 5'd21;
        wb_we = 1'b1; wb_rd = 5'd20; wb_val = 32'hC0DE_1234;
        @(posedge clk);
        commit_wb();
        @(negedge clk);
        wb_we = 1'b0; wb_val = 32'h0;
        #1;
        chk(sel_a == 2'b00, "R7 sel_a", {30'd0, sel_a}, 0);
        chk(op_a == 32'hC0DE_1234, "R7 op_a write-through", op_a, 32'hC0DE_1234);
        chk(op_b == 32'h0, "R7 op_b other reg", op_b, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(op_a == 32'hC0DE_1234, "R7 stored value", op_a, 32'hC0DE_1234);

        // R10 write to register 0 ignored
        @(negedge clk);
        id_rs_a = 5'd0; id_rs_b = 5'd0;
        wb_we = 1'b1; wb_rd = 5'd0; wb_val = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        wb_we = 1'b0;
        #1;
        chk(op_a == 0, "R10 bypass of reg0", op_a, 0);
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(op_b == 0, "R10 reg0 stored", op_b, 0);

        // R9 reset mid-run clears the register file
        @(negedge clk);
        id_rs_a = 5'd20; id_rs_b = 5'd4;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(op_a == 0 && sel_a == 2'b00, "R9 latch cleared", op_a, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        chk(op_a == 0, "R9 reg20 cleared", op_a, 0);
        chk(op_b == 0, "R9 reg4 cleared", op_b, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule